// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block takes one warp-wide scratchpad access, 32 lanes each carrying a word address and an active bit, and schedules it onto a scratchpad of 32 banks that are each one 4-byte word wide. Consecutive words sit in consecutive banks, so a lane's bank is its word address modulo 32. The block does not store data. It decides which lanes may touch the array in each bank cycle and emits that decision as a sequence of grant masks.

The conflict degree of a request is the largest number of distinct words that any single bank is asked for. The block computes it when the request is accepted and then replays the access over exactly that many grant beats. Each beat grants at most one word per bank. In each bank the word whose first requesting lane has the lowest number goes first. Lanes that name the same word are granted together. A column walk over a 32-word row stride therefore takes 32 beats, while the same walk over a 33-word padded stride takes one. The slowdown against a conflict-free access equals the degree.

Both edges are valid/ready streams. A request is taken only when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is high only while no grant sequence is outstanding, so a new request waits until the last beat of the previous one has been taken. A grant beat is presented on `gnt_valid` and is consumed on an edge where `gnt_ready` is high. While `gnt_ready` is low, the beat stays on the outputs unchanged. `conflict_ways` is a plain status output.

Top module: `scratch_bank_sched`

## Requirements
- R1: A lane's bank is the low 5 bits of its word address (address modulo 32). Active lanes whose words lie in different banks can be granted in the same beat.
- R2: On acceptance, `conflict_ways` is loaded with the largest count, over all banks, of distinct words requested by active lanes. It reads 0 for an all-inactive request and holds its value until the next acceptance.
- R3: A request with degree D >= 1 produces exactly D grant beats. A request with no active lane produces one beat with an all-zero mask.
- R4: In one beat, all granted lanes that share a bank request the same word. Every pending lane that names that word is granted in that beat.
- R5: In each bank, words are served in ascending order of the lowest-numbered active lane that requests each word, one word per beat.
- R6: Inactive lanes (`req_mask` bit 0) are never granted. Every active lane is granted in exactly one beat of its request.
- R7: `gnt_last` is high on the beat that grants the last still-pending lanes and low on every earlier beat.
- R8: All 32 lanes active, with lane i at address 32*i: 32 beats are produced, beat k grants only lane k, and `conflict_ways` is 32. With lane i at address 33*i: one beat grants all lanes and `conflict_ways` is 1.
- R9: After reset, `req_ready` is 1 and `gnt_valid` is 0. While `gnt_valid` is high and `gnt_ready` is low, `gnt_valid` and `gnt_mask` hold at the next cycle. `req_ready` is low from acceptance until the last beat is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; request taken at this edge if valid |
| req_mask | input | 32 | Active bit per lane, bit i for lane i |
| req_addr | input | 512 | Word address per lane, lane i in bits [16*i+15:16*i] |
| gnt_valid | output | 1 | Grant beat present |
| gnt_ready | input | 1 | Consumer takes the grant beat |
| gnt_mask | output | 32 | Lanes granted in this beat, bit i for lane i |
| gnt_last | output | 1 | This beat completes the request |
| conflict_ways | output | 6 | Conflict degree of the last accepted request |

## Verification
Two strided column walks pin down the extremes. The 32-word stride separates a correct bank mapping and one-lane-per-beat ordering from any grouping across lanes. The 33-word stride shows that distinct banks are served together. A request where every lane names one word, and a request with no active lane, tell grouping of shared words and the empty case apart from a plain count of active lanes. A half-active strided request checks that inactive lanes neither add beats nor receive grants. Random addresses confined to a few banks and a few words per bank, consumed through random back-pressure, exercise ordering inside each bank, the last flag and the holding of stalled beats.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  parameter int LANES = 32;
  parameter int BANKS = 32;
  parameter int AW    = 16;
endpackage

// File: rtl/sbs_degree.sv
module sbs_degree #(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int AW    = 16,
  localparam int BW   = $clog2(BANKS),
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0]         act,
  input  logic [LANES-1:0][AW-1:0] addr,
  output logic [CW-1:0]            degree
);
  // first occurrence of each distinct word among active lanes
  logic [LANES-1:0] first;
  logic [BANKS-1:0][CW-1:0] cnt;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      first[l] = act[l];
      for (int k = 0; k < l; k++)
        if (act[k] && addr[k] == addr[l]) first[l] = 1'b0;
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_comb begin
      cnt[b] = '0;
      for (int l = 0; l < LANES; l++)
        if (first[l] && addr[l][BW-1:0] == BW'(b)) cnt[b] = cnt[b] + CW'(1);
    end
  end

  always_comb begin
    degree = '0;
    for (int b = 0; b < BANKS; b++)
      if (cnt[b] > degree) degree = cnt[b];
  end

  // R2: the degree can never exceed the number of active lanes
  always_comb begin
    assert (int'(degree) <= $countones(act))
      else $error("a_r2_degree_bound");
  end
endmodule

// File: rtl/sbs_bank_pick.sv
module sbs_bank_pick #(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int AW    = 16,
  localparam int BW   = $clog2(BANKS)
) (
  input  logic [LANES-1:0]         pend,
  input  logic [LANES-1:0][AW-1:0] addr,
  output logic [LANES-1:0]         gnt
);
  logic [BANKS-1:0][LANES-1:0] bank_gnt;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic          found;
    logic [AW-1:0] sel;
    logic [LANES-1:0] row;

    // lowest pending lane in this bank chooses the word
    always_comb begin
      found = 1'b0;
      sel   = '0;
      for (int l = 0; l < LANES; l++)
        if (!found && pend[l] && addr[l][BW-1:0] == BW'(b)) begin
          found = 1'b1;
          sel   = addr[l];
        end
      for (int l = 0; l < LANES; l++)
        row[l] = found && pend[l] && addr[l] == sel;
    end
    assign bank_gnt[b] = row;
  end

  always_comb begin
    gnt = '0;
    for (int b = 0; b < BANKS; b++) gnt = gnt | bank_gnt[b];
  end
endmodule

// File: rtl/scratch_bank_sched.sv
module scratch_bank_sched
  import sbs_pkg::*;
#(
  parameter int NL   = LANES,
  parameter int NB   = BANKS,
  parameter int AWID = AW,
  localparam int BW  = $clog2(NB),
  localparam int CW  = $clog2(NL + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [NL-1:0]      req_mask,
  input  logic [NL*AWID-1:0] req_addr,
  output logic               gnt_valid,
  input  logic               gnt_ready,
  output logic [NL-1:0]      gnt_mask,
  output logic               gnt_last,
  output logic [CW-1:0]      conflict_ways
);
  logic                      busy;
  logic [NL-1:0]             pend;
  logic [NL-1:0][AWID-1:0]   addr_q;
  logic [NL-1:0][AWID-1:0]   addr_in;
  logic [CW-1:0]             ways_q;
  logic [CW-1:0]             deg_in;
  logic [CW-1:0]             beat_cnt;
  logic                      accept;
  logic                      fire;

  assign addr_in = req_addr;

  sbs_degree #(.LANES(NL), .BANKS(NB), .AW(AWID)) u_deg (
    .act    (req_mask),
    .addr   (addr_in),
    .degree (deg_in)
  );

  sbs_bank_pick #(.LANES(NL), .BANKS(NB), .AW(AWID)) u_pick (
    .pend (pend),
    .addr (addr_q),
    .gnt  (gnt_mask)
  );

  assign req_ready     = !busy;
  assign accept        = req_valid && !busy;
  assign gnt_valid     = busy;
  assign fire          = busy && gnt_ready;
  assign gnt_last      = (pend & ~gnt_mask) == '0;
  assign conflict_ways = ways_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      pend     <= '0;
      addr_q   <= '0;
      ways_q   <= '0;
      beat_cnt <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      pend     <= req_mask;
      addr_q   <= addr_in;
      ways_q   <= deg_in;
      beat_cnt <= '0;
    end else if (fire) begin
      pend     <= pend & ~gnt_mask;
      beat_cnt <= beat_cnt + CW'(1);
      if (gnt_last) busy <= 1'b0;
    end
  end

  // R6: grants only go to lanes still waiting
  a_r6_grant_in_pending: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |-> (gnt_mask & ~pend) == '0);

  // R3: each non-final beat with work left makes progress
  a_r3_progress: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid && pend != '0) |-> gnt_mask != '0);

  // R3: beats consumed equal the conflict degree (one for an empty request)
  a_r3_beats_match_ways: assert property (@(posedge clk) disable iff (rst)
    (fire && gnt_last) |->
      (beat_cnt + CW'(1)) == ((ways_q == '0) ? CW'(1) : ways_q));

  // R9: a stalled beat is held unchanged
  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid && !gnt_ready) |=> (gnt_valid && $stable(gnt_mask)));

  // R4: within one beat a bank delivers a single word
  always @(posedge clk) begin
    if (!rst && busy) begin
      for (int i = 0; i < NL; i++)
        for (int j = 0; j < NL; j++)
          if (gnt_mask[i] && gnt_mask[j] && addr_q[i][BW-1:0] == addr_q[j][BW-1:0])
            a_r4_one_word_per_bank: assert (addr_q[i] == addr_q[j])
              else $error("a_r4_one_word_per_bank");
    end
  end
endmodule

// File: tb/sim_scratch_bank_sched.sv
module sim_scratch_bank_sched;
  localparam int L  = 32;
  localparam int AW = 16;
  localparam int CW = 6;

  logic              clk = 1'b0;
  logic              rst;
  logic              req_valid;
  logic              req_ready;
  logic [L-1:0]      req_mask;
  logic [L*AW-1:0]   req_addr;
  logic              gnt_valid;
  logic              gnt_ready;
  logic [L-1:0]      gnt_mask;
  logic              gnt_last;
  logic [CW-1:0]     conflict_ways;

  always #10 clk = ~clk;

  scratch_bank_sched u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_mask(req_mask), .req_addr(req_addr), .gnt_valid(gnt_valid),
    .gnt_ready(gnt_ready), .gnt_mask(gnt_mask), .gnt_last(gnt_last),
    .conflict_ways(conflict_ways)
  );

  typedef struct {
    logic [L-1:0] m;
    logic         last;
    string        tag;
  } beat_t;

  beat_t expq[$];
  int    wayq[$];
  int    checks = 0;
  int    fails  = 0;
  bit    rdy_rand = 1'b0;
  bit    first_beat = 1'b1;
  bit    stall_seen = 1'b0;
  logic [L-1:0] stall_mask;
  bit    done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected schedule from rank of each word within its bank (R2 R3 R5 R7)
  task automatic model(input logic [L-1:0] mask, input logic [L-1:0][AW-1:0] a,
                       input string tag);
    logic [L-1:0] first;
    int fl[L];
    int rank[L];
    int n = 0;
    for (int l = 0; l < L; l++) begin
      first[l] = mask[l];
      fl[l] = l;
      for (int k = l - 1; k >= 0; k--)
        if (mask[k] && a[k] == a[l]) begin first[l] = 1'b0; fl[l] = k; end
    end
    for (int l = 0; l < L; l++) begin
      rank[l] = 0;
      if (mask[l]) begin
        for (int k = 0; k < fl[l]; k++)
          if (first[k] && a[k][4:0] == a[l][4:0]) rank[l]++;
        if (rank[l] + 1 > n) n = rank[l] + 1;
      end
    end
    wayq.push_back(n);
    for (int r = 0; r < ((n == 0) ? 1 : n); r++) begin
      beat_t e;
      e.m = '0;
      for (int l = 0; l < L; l++) if (mask[l] && rank[l] == r) e.m[l] = 1'b1;
      e.last = (n == 0) || (r == n - 1);
      e.tag  = tag;
      expq.push_back(e);
    end
  endtask

  task automatic send(input logic [L-1:0] mask, input logic [L-1:0][AW-1:0] a,
                      input string tag);
    model(mask, a, tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_mask  = mask;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    req_mask  = '0;
  endtask

  // Monitor: decide ready for the coming edge, then check what will fire
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (stall_seen) begin
        chk(gnt_valid == 1'b1, "R9", "stalled beat valid kept", gnt_valid, 1);
        chk(gnt_mask == stall_mask, "R9", "stalled beat mask kept", gnt_mask, stall_mask);
      end
      gnt_ready = rdy_rand ? (($urandom % 3) != 0) : 1'b1;
      stall_seen = gnt_valid && !gnt_ready;
      stall_mask = gnt_mask;
      if (gnt_valid && gnt_ready) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R3", "unexpected extra beat", gnt_mask, 0);
        end else begin
          beat_t e;
          e = expq.pop_front();
          if (first_beat) begin
            int w;
            w = wayq.pop_front();
            chk(int'(conflict_ways) == w, "R2", {e.tag, " conflict_ways"}, conflict_ways, w);
          end
          chk(gnt_mask == e.m, "R1/R4/R5/R6", {e.tag, " grant mask"}, gnt_mask, e.m);
          chk(gnt_last == e.last, "R7", {e.tag, " last flag"}, gnt_last, e.last);
          first_beat = gnt_last;
        end
      end
    end
  end

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog R3 actual=hung expected=done");
    done = 1'b1;
    summary();
  end

  initial begin
    logic [L-1:0][AW-1:0] a;
    rst = 1'b1; req_valid = 1'b0; req_mask = '0; req_addr = '0; gnt_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "reset req_ready", req_ready, 1);
    chk(gnt_valid == 1'b0, "R9", "reset gnt_valid", gnt_valid, 0);

    // R8: row stride 32, every lane in bank 0
    for (int l = 0; l < L; l++) a[l] = AW'(l * 32);
    send('1, a, "R8 stride32");
    @(negedge clk);
    chk(req_ready == 1'b0, "R9", "req_ready low while busy", req_ready, 0);

    // R8: padded stride 33, all banks distinct
    for (int l = 0; l < L; l++) a[l] = AW'(l * 33);
    send('1, a, "R8 stride33");

    // R4: every lane names one word
    for (int l = 0; l < L; l++) a[l] = 16'h0123;
    send('1, a, "R4 same word");

    // R3: empty request
    send('0, a, "R3 empty");

    // R6: odd lanes only, stride 32
    for (int l = 0; l < L; l++) a[l] = AW'(l * 32);
    send(32'hAAAA_AAAA, a, "R6 odd lanes");

    // R1: stride 1, one word per bank
    for (int l = 0; l < L; l++) a[l] = AW'(l + 64);
    send('1, a, "R1 stride1");

    // R5: reversed word order within bank 3
    for (int l = 0; l < L; l++) a[l] = AW'(((L - l) % 4) * 32 + 3);
    send('1, a, "R5 reversed");

    // random, few banks and few words per bank, with back-pressure
    rdy_rand = 1'b1;
    for (int t = 0; t < 40; t++) begin
      for (int l = 0; l < L; l++)
        a[l] = AW'((($urandom % 3) << 5) | ($urandom % 4));
      send($urandom, a, "R5 random");
    end

    while (expq.size() != 0 || !req_ready) @(negedge clk);
    @(negedge clk);
    chk(int'(conflict_ways) >= 0 && gnt_valid == 1'b0, "R9", "idle at end", gnt_valid, 0);
    done = 1'b1;
    summary();
  end
endmodule